// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a host-side SPI master that a processor drives through eight byte-wide registers. Software loads a frame of 8, 16, 24 or 32 bits into four data byte registers, picks the clock polarity, clock phase, bit order, clock divisor and one of four slave selects, and then writes the top data byte. That write starts the serial clock. The frame is shifted out on MOSI while MISO is shifted in.

Received bits replace the transmitted frame in place. A read of the data bytes after the busy flag clears therefore returns the slave's answer. Slave select either frames each transfer automatically or follows a software bit, so one select can stay low across several frames. A device interrupt line reaches the host only when software has enabled it.

Register map (3-bit address): 0 = control, 1 = configuration, 2 = status (read only), 3 = reads zero, 4 to 7 = data bytes 0 to 3. Data byte k holds frame bits 8k+7 down to 8k.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, every `ss_n_o` bit is 1, `sclk_o`, `mosi_o` and `irq_o` are 0, and control, configuration, status and data registers read 0.
- R2: A write to address 7 while busy is 0 starts a frame: status bit 0 (busy) is 1 from the next cycle until the frame ends.
- R3: Control bits [5:4] set the frame length: 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 32 bits. A frame of N bits makes exactly 2N SCLK transitions.
- R4: The frame occupies data bits 31 down to 32-N. With configuration bit 2 = 0, bit 31 is sent first and lower bits follow. With bit 2 = 1, bit 32-N is sent first and higher bits follow.
- R5: The i-th received bit is written to the same position as the i-th sent bit. Data bits below 32-N are left unchanged.
- R6: Configuration bit 0 (polarity) sets the SCLK idle level. Configuration bit 1 (phase) selects the edge: with phase 0, data is sampled on the leading edge and changed on the trailing edge; with phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: The SCLK half period is HALF_UNIT*(d+1) clock cycles, where d is configuration bits [6:4].
- R8: In automatic mode (control bit 3 = 0), only `ss_n_o[s]` is driven low, from one cycle after busy rises to one cycle after it falls, where s is control bits [1:0]. No more than one select is ever low.
- R9: In manual mode (control bit 3 = 1), `ss_n_o[s]` is low exactly when control bit 2 is 1, one cycle after the write, and it stays low across back-to-back frames.
- R10: While busy is 1, writes to the data, control and configuration registers are ignored.
- R11: `irq_o` equals `dev_irq_i` AND configuration bit 3, registered one cycle. Status bit 1 shows `dev_irq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` one cycle later |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NUM_SS | Active-low slave selects |
| dev_irq_i | input | 1 | Device interrupt request |
| irq_o | output | 1 | Gated interrupt to the host |

## Verification
Frames are run under directed and seeded random combinations of length, polarity, phase, bit order, divisor and select index. A bench slave model records every MOSI bit on its sample edge and returns a known word on MISO.

- The recorded bit string separates a wrong bit order or a wrong frame window from a correct one.
- The read-back data shows whether received bits land in the right positions and whether the bytes outside the window are left alone.
- The SCLK edge count and the span between the first and last edge pin down the length decode and the divisor.
- A 24-bit frame, with a data and configuration write made while busy, shows whether blocked writes leak into byte 0 or into the configuration.
- Two manual-mode frames in a row show whether the select stays low between frames.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int FRAME_MAX = 32;
  localparam int DIV_W     = 3;
  localparam int SEL_W     = 2;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CFG   = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_DTOP  = 3'd7;

  typedef struct packed {
    logic [1:0]       spare;
    logic [1:0]       len;
    logic             manual;
    logic             man_on;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  typedef struct packed {
    logic             spare;
    logic [DIV_W-1:0] div;
    logic             irq_en;
    logic             lsb;
    logic             cpha;
    logic             cpol;
  } cfg_t;

  // lowest bit position of the frame window
  function automatic logic [4:0] frame_lo(logic [1:0] len);
    return {~len, 3'b000};
  endfunction

  function automatic logic head_bit(logic [FRAME_MAX-1:0] d, logic [1:0] len, logic lsb);
    logic [4:0] lo;
    lo = frame_lo(len);
    return lsb ? d[lo] : d[FRAME_MAX-1];
  endfunction

  function automatic logic [FRAME_MAX-1:0] shift_in(logic [FRAME_MAX-1:0] d,
                                                     logic [1:0] len, logic lsb, logic b);
    logic [4:0]           lo;
    logic [FRAME_MAX-1:0] win;
    logic [FRAME_MAX-1:0] nd;
    lo  = frame_lo(len);
    win = {FRAME_MAX{1'b1}} << lo;
    nd  = d & ~win;
    if (lsb) begin
      nd = nd | ((d >> 1) & win);
      nd[FRAME_MAX-1] = b;
    end else begin
      nd = nd | ((d << 1) & win);
      nd[lo] = b;
    end
    return nd;
  endfunction
endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv
  import spi_host_pkg::*;
#(
  parameter int HALF_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = $clog2(HALF_UNIT << DIV_W) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  assign half = CNT_W'(HALF_UNIT) * (CNT_W'(div) + CNT_W'(1));
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (!run || cnt == '0)   cnt <= half - CNT_W'(1);
    else                          cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 data_we,
  input  logic [1:0]           data_idx,
  input  logic [7:0]           data_wdata,
  input  logic                 start,
  input  logic [1:0]           len_in,
  input  logic                 cpol_in,
  input  logic                 cpha_in,
  input  logic                 lsb_in,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 busy,
  output logic                 sclk,
  output logic                 mosi,
  output logic [FRAME_MAX-1:0] data
);
  logic [FRAME_MAX-1:0] data_w;
  logic [FRAME_MAX-1:0] data_sh;
  logic [6:0]           k;
  logic [6:0]           n2;
  logic [1:0]           len_q;
  logic                 cpha_q;
  logic                 lsb_q;
  logic                 rx_q;

  always_comb begin
    data_w = data;
    data_w[8*data_idx +: 8] = data_wdata;
  end

  assign n2      = 7'({len_q, 4'b0000}) + 7'd16;
  assign data_sh = shift_in(data, len_q, lsb_q, cpha_q ? miso : rx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      busy   <= 1'b0;
      k      <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      rx_q   <= 1'b0;
      len_q  <= '0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
    end else if (!busy) begin
      sclk <= cpol_in;
      if (data_we) data <= data_w;
      if (start) begin
        busy   <= 1'b1;
        k      <= '0;
        len_q  <= len_in;
        cpha_q <= cpha_in;
        lsb_q  <= lsb_in;
        mosi   <= head_bit(data_w, len_in, lsb_in);
      end
    end else if (tick) begin
      k <= k + 7'd1;
      if (k == n2 + 7'd1) begin
        busy <= 1'b0;
      end else if (k != '0) begin
        sclk <= ~sclk;
        if (k[0]) begin
          if (!cpha_q) rx_q <= miso;
          else         mosi <= head_bit(data, len_q, lsb_q);
        end else begin
          data <= data_sh;
          if (!cpha_q) mosi <= head_bit(data_sh, len_q, lsb_q);
        end
      end
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [2:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  input  logic                 busy,
  input  logic                 dev_irq,
  input  logic [FRAME_MAX-1:0] data,
  output logic [7:0]           reg_rdata,
  output ctrl_t                ctrl,
  output cfg_t                 cfg,
  output logic                 irq,
  output logic                 data_we,
  output logic [1:0]           data_idx,
  output logic                 start
);
  logic       accept;
  logic [7:0] rd_mux;

  assign accept   = reg_wr && !busy;
  assign data_we  = accept && reg_addr[2];
  assign data_idx = reg_addr[1:0];
  assign start    = accept && (reg_addr == A_DTOP);

  always_comb begin
    if (reg_addr[2])               rd_mux = data[8*reg_addr[1:0] +: 8];
    else if (reg_addr == A_CTRL)   rd_mux = ctrl;
    else if (reg_addr == A_CFG)    rd_mux = cfg;
    else if (reg_addr == A_STAT)   rd_mux = {6'b0, dev_irq, busy};
    else                           rd_mux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      cfg       <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (accept && reg_addr == A_CTRL) ctrl <= ctrl_t'(reg_wdata);
      if (accept && reg_addr == A_CFG)  cfg  <= cfg_t'(reg_wdata);
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= dev_irq && cfg.irq_en;
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int NUM_SS    = 4,
  parameter int HALF_UNIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_n_o,
  input  logic              dev_irq_i,
  output logic              irq_o
);
  ctrl_t                ctrl;
  cfg_t                 cfg;
  logic                 busy;
  logic                 tick;
  logic                 data_we;
  logic [1:0]           data_idx;
  logic                 start;
  logic [FRAME_MAX-1:0] data;
  logic                 man_mode;
  logic                 irq_en;
  logic                 sel_act;

  assign man_mode = ctrl.manual;
  assign irq_en   = cfg.irq_en;
  assign sel_act  = ctrl.manual ? ctrl.man_on : busy;

  spi_host_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .dev_irq(dev_irq_i), .data(data),
    .reg_rdata(reg_rdata), .ctrl(ctrl), .cfg(cfg), .irq(irq_o),
    .data_we(data_we), .data_idx(data_idx), .start(start)
  );

  spi_host_clkdiv #(.HALF_UNIT(HALF_UNIT)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(cfg.div), .tick(tick)
  );

  spi_host_shift u_shift (
    .clk(clk), .rst(rst), .data_we(data_we), .data_idx(data_idx),
    .data_wdata(reg_wdata), .start(start), .len_in(ctrl.len),
    .cpol_in(cfg.cpol), .cpha_in(cfg.cpha), .lsb_in(cfg.lsb),
    .tick(tick), .miso(miso_i), .busy(busy), .sclk(sclk_o), .mosi(mosi_o),
    .data(data)
  );

  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    always_ff @(posedge clk) begin
      if (rst) ss_n_o[g] <= 1'b1;
      else     ss_n_o[g] <= !(sel_act && ctrl.sel == SEL_W'(g));
    end
  end
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_SS-1:0] ss_n,
  input logic              busy,
  input logic              manual,
  input logic              tick,
  input logic [31:0]       data,
  input logic              wr,
  input logic [2:0]        addr,
  input logic              irq,
  input logic              dev_irq,
  input logic              irq_en
);
  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~ss_n) <= 1);

  // R8
  auto_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !manual) |-> (ss_n != {NUM_SS{1'b1}}));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(data));

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr && addr == 3'd7));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(dev_irq && irq_en)));
endmodule

bind spi_host_ctrl spi_host_chk #(.NUM_SS(NUM_SS)) u_chk (
  .clk(clk), .rst(rst), .ss_n(ss_n_o), .busy(busy), .manual(man_mode),
  .tick(tick), .data(data), .wr(reg_wr), .addr(reg_addr), .irq(irq_o),
  .dev_irq(dev_irq_i), .irq_en(irq_en)
);

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sclk, mosi;
  logic       miso = 1'b0;
  logic [3:0] ss_n;
  logic       dev_irq = 1'b0;
  logic       irq;

  int checks = 0, errors = 0;

  logic        s_cpol = 0, s_cpha = 0;
  logic [31:0] slv_word = '0, rec = '0;
  int          sidx = 0, ridx = 0, edge_cnt = 0, ss_bad = 0;
  realtime     t_first = 0, t_last = 0;
  logic [3:0]  ss_exp = 4'hF;

  spi_host_ctrl #(.NUM_SS(4), .HALF_UNIT(HALF)) i_spi_host_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .ss_n_o(ss_n), .dev_irq_i(dev_irq), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // bench slave
  always @(sclk) begin
    if (ss_n != 4'hF) begin
      edge_cnt++;
      if (edge_cnt == 1) t_first = $realtime;
      t_last = $realtime;
      if (ss_n != ss_exp) ss_bad++;
      if (sclk != s_cpol) begin
        if (!s_cpha) begin if (ridx < 32) rec[ridx] = mosi; ridx++; end
        else begin if (sidx < 32) miso = slv_word[sidx]; sidx++; end
      end else begin
        if (!s_cpha) begin sidx++; if (sidx < 32) miso = slv_word[sidx]; end
        else begin if (ridx < 32) rec[ridx] = mosi; ridx++; end
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd2, st);
      if (!st[0]) return;
    end
    chk("R2 frame completes", 1, 0);
  endtask

  function automatic int bpos(int len, bit lsb, int i);
    int lo = (3 - len) * 8;
    return lsb ? lo + i : 31 - i;
  endfunction

  task automatic frame(logic [1:0] len, bit cpol, bit cpha, bit lsb, logic [2:0] div,
                       logic [1:0] sel, bit man, logic [31:0] d, logic [31:0] s, bit poke);
    int n = 8 * (int'(len) + 1);
    int half = HALF * (int'(div) + 1);
    logic [7:0]  cfgv = {1'b0, div, 1'b0, lsb, cpha, cpol};
    logic [31:0] exp_rx = d, exp_rec = '0, got;
    logic [63:0] mask = (64'd1 << n) - 64'd1;
    logic [7:0]  b;
    wr(3'd1, cfgv);
    wr(3'd0, {2'b00, len, man, man, sel});
    ss_exp = 4'hF & ~(4'b0001 << sel);
    if (man) begin
      @(negedge clk);
      chk("R9 manual select asserted", ss_n, ss_exp);
    end
    s_cpol = cpol; s_cpha = cpha; slv_word = s; rec = '0;
    sidx = 0; ridx = 0; edge_cnt = 0; ss_bad = 0;
    miso = cpha ? 1'b0 : s[0];
    wr(3'd4, d[7:0]); wr(3'd5, d[15:8]); wr(3'd6, d[23:16]); wr(3'd7, d[31:24]);
    if (poke) begin
      rd(3'd2, b);
      chk("R2 busy after top byte write", b[0], 1);
      wr(3'd4, ~d[7:0]);
      wr(3'd1, 8'h7E);
      wr(3'd0, 8'h00);
    end
    wait_idle();
    for (int i = 0; i < n; i++) begin
      exp_rec[i] = d[bpos(len, lsb, i)];
      exp_rx[bpos(len, lsb, i)] = s[i];
    end
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), b);
      got[8*k +: 8] = b;
    end
    chk("R3 sclk transitions", edge_cnt, 2 * n);
    chk("R7 edge span in cycles", int'((t_last - t_first) / 5.0), (2 * n - 1) * half);
    chk("R4 bits seen by slave", {32'd0, rec} & mask, {32'd0, exp_rec} & mask);
    chk("R5 data after frame", got, exp_rx);
    chk("R8 select during frame", ss_bad, 0);
    chk("R6 idle clock level", sclk, cpol);
    chk(man ? "R9 select held" : "R8 select released", ss_n, man ? ss_exp : 4'hF);
    if (poke) begin
      rd(3'd1, b);
      chk("R10 config write blocked", b, cfgv);
      rd(3'd0, b);
      chk("R10 control write blocked", b, {2'b00, len, man, man, sel});
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 ss_n at reset", ss_n, 4'hF);
    chk("R1 sclk at reset", sclk, 0);
    chk("R1 mosi at reset", mosi, 0);
    chk("R1 irq at reset", irq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register at reset", v, 0);
    end
    // directed: full 32-bit, mode 0, msb first
    frame(2'd3, 0, 0, 0, 3'd0, 2'd0, 0, 32'hA5C3_0F81, 32'h1234_5678, 0);
    // directed: 8-bit, lsb first, mode 3, lower bytes preserved
    frame(2'd0, 1, 1, 1, 3'd1, 2'd2, 0, 32'h3C11_2233, 32'h0000_00B6, 0);
    // directed: 16-bit, mode 1, slowest divisor
    frame(2'd1, 0, 1, 0, 3'd7, 2'd3, 0, 32'h8001_FFFF, 32'h0000_5A5A, 0);
    // R10 writes while busy, 24-bit leaves byte 0
    frame(2'd2, 1, 0, 0, 3'd3, 2'd1, 0, 32'hC0FF_EE42, 32'h00AB_CDEF, 1);
    // R9 manual mode, two frames back to back
    frame(2'd1, 0, 0, 1, 3'd0, 2'd1, 1, 32'h1357_0000, 32'h0000_9BDF, 0);
    frame(2'd1, 0, 0, 1, 3'd0, 2'd1, 1, 32'h2468_0000, 32'h0000_1F2E, 0);
    wr(3'd0, {2'b00, 2'd1, 1'b1, 1'b0, 2'd1});
    @(negedge clk);
    chk("R9 manual select released", ss_n, 4'hF);
    wr(3'd0, 8'h00);
    // R11 interrupt gating
    dev_irq = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 irq blocked when disabled", irq, 0);
    rd(3'd2, v);
    chk("R11 status shows device irq", v[1], 1);
    wr(3'd1, 8'h08);
    @(negedge clk);
    chk("R11 irq passes when enabled", irq, 1);
    dev_irq = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 irq follows device", irq, 0);
    wr(3'd1, 8'h00);
    // random frames
    for (int i = 0; i < 20; i++) begin
      frame(2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom % 4),
            2'($urandom % 4), 0, $urandom, $urandom, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule